// File: doc/BRIEF.md
# Charger Safety Timer Bank

This block holds the three watchdog timers of a lithium cell charge sequencer. A precondition timer bounds the trickle phase. A fast-charge timer bounds the constant-current phase. An elapsed timer bounds the whole bulk charge, from the start of constant current through constant voltage. The sequencer reports its phase on a two-bit input, and a base oscillator supplies a one-cycle tick enable. Each timer raises a sticky expiry flag when its budget of ticks runs out. The sequencer reads these flags to declare a fault or to end the charge.

All periods come from one timebase. `HALF_SEC_TICKS` stands in for the external timing capacitor and sets how many base ticks make half a second. The nominal budgets are one hour, one and a half hours and three hours, so they stand in the ratio 2:3:6 of a half-hour unit. `TEST_MODE` shrinks the unit from 1800 s to 4 s, which lets a bench reach every expiry in a few hundred ticks. During thermal regulation the timers slow down in proportion to the throttled charge current. This keeps a charge that is held back by heat from timing out early.

The block also divides the base tick into a 50% duty flash clock for status indicators. This clock runs at 1 Hz at the reference timebase and is never throttled. All pins are plain level or pulse signals. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `chg_safety_timers`

## Requirements
- R1: After reset, all three expiry flags and the flash output are 0.
- R2: In phase 1 (precondition), the precondition flag rises after exactly 2×UNIT advance ticks and not earlier. Here UNIT = 2×HALF_SEC_TICKS×(TEST_MODE ? 4 : 1800). Cycles without `tick_i` do not advance any timer.
- R3: The precondition count is cleared whenever the phase is not 1. A return to phase 1 needs a full fresh budget.
- R4: In phase 2 (constant current), the fast-charge flag rises after exactly 3×UNIT advance ticks. The count is cleared in any other phase, including phase 3.
- R5: The elapsed timer counts in both phase 2 and phase 3, carrying its count across the change from 2 to 3. Its flag rises after exactly 6×UNIT advance ticks.
- R6: Phase 0 (qualification) clears every timer count.
- R7: An expiry flag stays set until `clr_i` is high for a cycle. `clr_i` drops all three flags. A phase change does not drop a flag.
- R8: With `thr_en_i` low, every base tick is an advance tick. With `thr_en_i` high, a 4-bit accumulator adds `thr_ratio_i` on each tick. A tick advances the timers only when the sum carries out, so k ticks from a cleared accumulator give floor(k×ratio/16) advances. A ratio of 0 freezes the timers. The accumulator is cleared while `thr_en_i` is low.
- R9: `flash_o` toggles on every HALF_SEC_TICKS-th base tick counted from reset. Phase and throttle do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle base oscillator tick |
| phase_i | input | 2 | Sequencer phase: 0 qualify, 1 precondition, 2 constant current, 3 constant voltage |
| thr_en_i | input | 1 | Thermal regulation active |
| thr_ratio_i | input | 4 | Charge-current ratio in sixteenths while throttled |
| clr_i | input | 1 | Clears all expiry flags |
| pre_exp_o | output | 1 | Precondition timer expired (sticky) |
| fast_exp_o | output | 1 | Fast-charge timer expired (sticky) |
| term_exp_o | output | 1 | Elapsed timer expired (sticky) |
| flash_o | output | 1 | 50% duty status flash clock |

## Verification
A vector walk drives one charge profile in which each segment stops one tick short of a limit and the next segment crosses it. This separates a correct limit from an off-by-one limit on each of the three timers. One segment leaves precondition and returns to it, so a count that was never cleared would fire too early. The run through constant voltage shows that the fast count stops while the elapsed count carries on. Throttled segments use ratios of 8, 0 and 15 so that each ratio gives a distinct advance count, and directed tests cover the reset state, idle cycles and the flash cadence.

// File: rtl/chg_tmr_pkg.sv
package chg_tmr_pkg;

  typedef enum logic [1:0] {
    PH_QUAL   = 2'd0,
    PH_PRECON = 2'd1,
    PH_CC     = 2'd2,
    PH_CV     = 2'd3
  } phase_e;

  localparam int unsigned N_TIMERS = 3;

  // timer index 0: precondition, 1: fast charge, 2: elapsed
  function automatic int unsigned units_of(input int idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      default: return 6;
    endcase
  endfunction

  function automatic logic [N_TIMERS-1:0] run_mask(input phase_e ph);
    case (ph)
      PH_PRECON: return 3'b001;
      PH_CC:     return 3'b110;
      PH_CV:     return 3'b100;
      default:   return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/chg_tick_throttle.sv
module chg_tick_throttle #(
  parameter int unsigned RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          thr_en_i,
  input  logic [RW-1:0] ratio_i,
  output logic          adv_o
);
  logic [RW-1:0] acc_q;
  logic [RW:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, ratio_i};
  assign adv_o = tick_i & (~thr_en_i | sum[RW]);

  always_ff @(posedge clk) begin
    if (!rst_n || !thr_en_i) acc_q <= '0;
    else if (tick_i)         acc_q <= sum[RW-1:0];
  end

  p_full_speed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_en_i && tick_i) |-> adv_o);
  p_zero_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_en_i && ratio_i == '0) |-> !adv_o);
  p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |-> !adv_o);
endmodule

// File: rtl/chg_expiry_timer.sv
module chg_expiry_timer #(
  parameter int unsigned LIM = 32,
  parameter int unsigned W   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic adv_i,
  input  logic clr_i,
  output logic exp_o
);
  localparam logic [W-1:0] FULL = W'(LIM);
  localparam logic [W-1:0] LAST = W'(LIM - 1);

  logic [W-1:0] cnt_q;
  logic         exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (!run_i)                       cnt_q <= '0;
      else if (adv_i && cnt_q != FULL)  cnt_q <= cnt_q + 1'b1;
      if (clr_i)                                  exp_q <= 1'b0;
      else if (run_i && adv_i && cnt_q == LAST)   exp_q <= 1'b1;
    end
  end

  assign exp_o = exp_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_rise_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_q) |-> cnt_q == FULL);
  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_q && !clr_i) |=> exp_q);
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !exp_q);
endmodule

// File: rtl/chg_flash_div.sv
module chg_flash_div #(
  parameter int unsigned HALF = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic flash_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          flash_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flash_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == TOP) begin
        cnt_q   <= '0;
        flash_q <= ~flash_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flash_o = flash_q;

  p_flash_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(flash_q));
  p_flash_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
endmodule

// File: rtl/chg_safety_timers.sv
module chg_safety_timers
  import chg_tmr_pkg::*;
#(
  parameter int unsigned HALF_SEC_TICKS = 16,
  parameter bit          TEST_MODE      = 1'b0,
  parameter int unsigned RATIO_W        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [1:0]         phase_i,
  input  logic               thr_en_i,
  input  logic [RATIO_W-1:0] thr_ratio_i,
  input  logic               clr_i,
  output logic               pre_exp_o,
  output logic               fast_exp_o,
  output logic               term_exp_o,
  output logic               flash_o
);
  localparam int unsigned UNIT_SEC   = TEST_MODE ? 4 : 1800;
  localparam int unsigned UNIT_TICKS = 2 * HALF_SEC_TICKS * UNIT_SEC;
  localparam int unsigned MAX_LIM    = units_of(2) * UNIT_TICKS;
  localparam int unsigned TW         = $clog2(MAX_LIM + 1);

  logic                adv;
  logic [N_TIMERS-1:0] run;
  logic [N_TIMERS-1:0] exp_flags;

  assign run = run_mask(phase_e'(phase_i));

  chg_tick_throttle #(.RW(RATIO_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .thr_en_i(thr_en_i), .ratio_i(thr_ratio_i), .adv_o(adv)
  );

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    chg_expiry_timer #(.LIM(units_of(g) * UNIT_TICKS), .W(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run_i(run[g]), .adv_i(adv),
      .clr_i(clr_i), .exp_o(exp_flags[g])
    );
  end

  chg_flash_div #(.HALF(HALF_SEC_TICKS)) u_flash (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .flash_o(flash_o)
  );

  assign pre_exp_o  = exp_flags[0];
  assign fast_exp_o = exp_flags[1];
  assign term_exp_o = exp_flags[2];

  p_fast_before_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(term_exp_o) && phase_i == 2'd2 && !clr_i) |-> fast_exp_o);
endmodule

// File: tb/chg_safety_timers_test.sv
module chg_safety_timers_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic [1:0] phase_i = 2'd0;
  logic thr_en_i = 1'b0;
  logic [3:0] thr_ratio_i = 4'd0;
  logic clr_i = 1'b0;
  logic pre_exp_o, fast_exp_o, term_exp_o, flash_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // HALF=2, test unit 4 s: UNIT=16, limits 32 / 48 / 96 advance ticks
  chg_safety_timers #(.HALF_SEC_TICKS(2), .TEST_MODE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .phase_i(phase_i),
    .thr_en_i(thr_en_i), .thr_ratio_i(thr_ratio_i), .clr_i(clr_i),
    .pre_exp_o(pre_exp_o), .fast_exp_o(fast_exp_o),
    .term_exp_o(term_exp_o), .flash_o(flash_o)
  );

  typedef struct packed {
    logic       clr;
    logic [1:0] ph;
    logic       en;
    logic [3:0] ratio;
    logic [7:0] n;
    logic       e_pre;
    logic       e_fast;
    logic       e_term;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 1'b0, 4'd0,  8'd31, 1'b0, 1'b0, 1'b0},  // R2 one short
    '{1'b0, 2'd1, 1'b0, 4'd0,  8'd1,  1'b1, 1'b0, 1'b0},  // R2 limit
    '{1'b0, 2'd2, 1'b0, 4'd0,  8'd47, 1'b1, 1'b0, 1'b0},  // R4 short, R7 sticky
    '{1'b0, 2'd2, 1'b0, 4'd0,  8'd1,  1'b1, 1'b1, 1'b0},  // R4 limit
    '{1'b0, 2'd3, 1'b0, 4'd0,  8'd47, 1'b1, 1'b1, 1'b0},  // R5 short
    '{1'b0, 2'd3, 1'b0, 4'd0,  8'd1,  1'b1, 1'b1, 1'b1},  // R5 limit
    '{1'b1, 2'd0, 1'b0, 4'd0,  8'd5,  1'b0, 1'b0, 1'b0},  // R7 clear, R6
    '{1'b0, 2'd1, 1'b0, 4'd0,  8'd20, 1'b0, 1'b0, 1'b0},  // R3 partial
    '{1'b0, 2'd2, 1'b0, 4'd0,  8'd1,  1'b0, 1'b0, 1'b0},  // R3 leave
    '{1'b0, 2'd1, 1'b0, 4'd0,  8'd31, 1'b0, 1'b0, 1'b0},  // R3 fresh budget
    '{1'b0, 2'd1, 1'b0, 4'd0,  8'd1,  1'b1, 1'b0, 1'b0},  // R3 limit
    '{1'b1, 2'd2, 1'b1, 4'd8,  8'd94, 1'b0, 1'b0, 1'b0},  // R8 half: 47 adv
    '{1'b0, 2'd2, 1'b1, 4'd8,  8'd2,  1'b0, 1'b1, 1'b0},  // R8 half: 48 adv
    '{1'b0, 2'd3, 1'b1, 4'd0,  8'd40, 1'b0, 1'b1, 1'b0},  // R8 frozen
    '{1'b0, 2'd3, 1'b1, 4'd15, 8'd51, 1'b0, 1'b1, 1'b0},  // R8 15/16: 47 adv
    '{1'b0, 2'd3, 1'b1, 4'd15, 8'd1,  1'b0, 1'b1, 1'b1},  // R8 48 adv, R5
    '{1'b1, 2'd0, 1'b0, 4'd0,  8'd0,  1'b0, 1'b0, 1'b0}   // R7 clear
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_i = 1'b0; clr_i = 1'b0;
    phase_i = 2'd0; thr_en_i = 1'b0; thr_ratio_i = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    phase_i = v.ph; thr_en_i = v.en; thr_ratio_i = v.ratio;
    if (v.clr) begin
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
    end
    ticks(int'(v.n));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 pre", pre_exp_o, 1'b0);
    check("R1 fast", fast_exp_o, 1'b0);
    check("R1 term", term_exp_o, 1'b0);
    check("R1 flash", flash_o, 1'b0);

    // R9 flash cadence: toggles at tick 2, 4, 6
    ticks(1); check("R9 flash after 1", flash_o, 1'b0);
    ticks(1); check("R9 flash after 2", flash_o, 1'b1);
    ticks(2); check("R9 flash after 4", flash_o, 1'b0);
    phase_i = 2'd1; thr_en_i = 1'b1; thr_ratio_i = 4'd0;
    ticks(2); check("R9 flash unthrottled", flash_o, 1'b1);

    // R2 idle cycles do not advance
    do_reset();
    phase_i = 2'd1;
    ticks(31);
    repeat (20) @(negedge clk);
    check("R2 idle no advance", pre_exp_o, 1'b0);
    ticks(1);
    check("R2 limit after idle", pre_exp_o, 1'b1);

    // vector walk
    do_reset();
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      check($sformatf("R2/R4/R5 pre vec%0d", k), pre_exp_o, VEC[k].e_pre);
      check($sformatf("R4 fast vec%0d", k), fast_exp_o, VEC[k].e_fast);
      check($sformatf("R5 term vec%0d", k), term_exp_o, VEC[k].e_term);
    end

    // R6: qualification clears counts; R7 flags held across phase change
    do_reset();
    phase_i = 2'd2;
    ticks(40);
    phase_i = 2'd0;
    @(negedge clk);
    phase_i = 2'd2;
    ticks(47);
    check("R6 fast count cleared", fast_exp_o, 1'b0);
    ticks(1);
    check("R6 fast fresh limit", fast_exp_o, 1'b1);
    phase_i = 2'd0;
    repeat (3) @(negedge clk);
    check("R7 held in qualify", fast_exp_o, 1'b1);

    finish_run();
  end
endmodule